// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a single byte into an external 16K x 8 ultraviolet-erasable EPROM. A write request carries a 14-bit address, an 8-bit byte and a verify flag. The sequencer then drives the memory's address lines, data bus, chip-select, read-enable, program-strobe and programming-voltage switch through a fixed series of phases. It raises a one-cycle completion pulse when the series ends.

Each wait comes from a nanosecond parameter. That value is converted at elaboration time into a count of system clock cycles, rounded up. A single down-counter is reloaded at each phase boundary, so the same hardware times the microsecond setup windows and the roughly 50 ms programming strobe. When the verify flag is set, the sequencer adds a read-back phase after the data hold window. In that phase it releases the data bus, enables the memory's outputs, samples the returned byte at the end of an access window and flags any difference from the written byte.

The phase order is as follows:
- Drive address and data, and switch on the programming voltage.
- Lower chip-select.
- Strobe for the pulse width.
- Release the strobe and hold the data.
- Verify, if requested.
- Switch the voltage off and signal completion.

Top module: `eprom_prog_seq`

## Requirements
- R1: After synchronous reset, busy, done, mismatch, ep_vpp_en and ep_data_oe are 0, and ep_ce_n, ep_oe_n and ep_pgm_n are 1.
- R2: A request seen with req_valid=1 while idle is accepted at that clock edge. From the next cycle, busy=1, ep_vpp_en=1 and ep_data_oe=1. ep_addr and ep_data_out show the request's address and byte and keep them unchanged until the completion cycle.
- R3: ep_vpp_en is high for exactly SETUP_CYC cycles before ep_ce_n falls. SETUP_CYC is ceil(SETUP_NS*CLK_KHZ/1e6), and never less than 1.
- R4: ep_ce_n is low for exactly SETUP_CYC cycles before ep_pgm_n falls.
- R5: ep_pgm_n stays low for exactly PULSE_CYC = ceil(PULSE_NS*CLK_KHZ/1e6) cycles.
- R6: After ep_pgm_n rises, ep_data_oe stays 1 with unchanged data for exactly HOLD_CYC = ceil(HOLD_NS*CLK_KHZ/1e6) cycles.
- R7: With req_verify=1, after the hold window the sequencer drives ep_data_oe=0 and ep_oe_n=0, while ep_ce_n stays 0, for ACCESS_CYC = ceil(ACCESS_NS*CLK_KHZ/1e6) cycles. It samples ep_data_in at the last of these cycles. mismatch becomes 1 in the completion cycle if the sampled byte differs from the written byte, and 0 otherwise.
- R8: The completion cycle follows the hold window, or the verify window when verify is on. In it, done=1, busy=1, ep_vpp_en=0, ep_ce_n=1 and ep_data_oe=0. The next cycle is idle, with done=0 and busy=0.
- R9: req_valid is ignored in every busy cycle, including the completion cycle. The address and byte driven do not change.
- R10: mismatch is cleared when a new request is accepted. A run without verify ends with mismatch=0.
- R11: ep_oe_n is never 0 while ep_data_oe is 1. ep_pgm_n is 0 only while ep_vpp_en=1, ep_ce_n=0 and ep_data_oe=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | 14 | Byte address to program |
| req_data | input | 8 | Byte to program |
| req_verify | input | 1 | Add a read-back compare phase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Read-back differed from written byte |
| ep_addr | output | 14 | Address lines to the EPROM |
| ep_data_out | output | 8 | Byte driven onto the EPROM data bus |
| ep_data_oe | output | 1 | Data bus driver enable |
| ep_data_in | input | 8 | Byte returned by the EPROM |
| ep_ce_n | output | 1 | Chip select, active low |
| ep_oe_n | output | 1 | Output enable of the memory, active low |
| ep_pgm_n | output | 1 | Programming strobe, active low |
| ep_vpp_en | output | 1 | Programming-voltage switch enable |

## Verification
Two events can fall in the same cycle: the completion pulse and a fresh request. A related coincidence is that the verify result is registered at the very edge that enters completion. The bench holds req_valid high through whole runs, changing the address every cycle, so one request lands exactly on the done cycle. The model expects that request to be dropped and the next request to be taken one cycle later, and it compares the driven address on every cycle. The mismatch flag is judged in the done cycle itself, and again at the following acceptance, where it must clear.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_VPP_SETUP,
        PH_CE_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_VERIFY,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              verify;
    } wr_req_t;

    typedef struct packed {
        logic vpp_en;
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic data_oe;
    } pin_ctl_t;

    // Round a nanosecond interval up to whole clock cycles, at least one.
    function automatic longint ns_to_cycles(longint ns, longint khz);
        longint c;
        c = (ns * khz + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic pin_ctl_t decode_pins(phase_e ph);
        pin_ctl_t p;
        p = '{vpp_en: 1'b0, ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, data_oe: 1'b0};
        case (ph)
            PH_VPP_SETUP: begin p.vpp_en = 1'b1; p.data_oe = 1'b1; end
            PH_CE_SETUP:  begin p.vpp_en = 1'b1; p.data_oe = 1'b1; p.ce_n = 1'b0; end
            PH_PULSE:     begin p.vpp_en = 1'b1; p.data_oe = 1'b1; p.ce_n = 1'b0; p.pgm_n = 1'b0; end
            PH_HOLD:      begin p.vpp_en = 1'b1; p.data_oe = 1'b1; p.ce_n = 1'b0; end
            PH_VERIFY:    begin p.vpp_en = 1'b1; p.ce_n = 1'b0; p.oe_n = 1'b0; end
            default:      ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eprom_phase_timer.sv
module eprom_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // The counter never wraps below zero.
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);
endmodule

// File: rtl/eprom_verify_cmp.sv
module eprom_verify_cmp
    import eprom_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] expected,
    input  logic [DATA_W-1:0] returned,
    output logic              mismatch
);
    always_ff @(posedge clk) begin
        if (rst || clear) mismatch <= 1'b0;
        else if (sample)  mismatch <= (returned != expected);
    end

    p_clear_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> !mismatch);
    p_flag_only_on_sample_r7: assert property (@(posedge clk) disable iff (rst)
        (!sample && !clear) |=> $stable(mismatch));
endmodule

// File: rtl/eprom_seq_fsm.sv
module eprom_seq_fsm
    import eprom_prog_pkg::*;
#(
    parameter int         W         = 8,
    parameter logic [W-1:0] SETUP_LD  = '0,
    parameter logic [W-1:0] PULSE_LD  = '0,
    parameter logic [W-1:0] HOLD_LD   = '0,
    parameter logic [W-1:0] ACCESS_LD = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         verify_q,
    input  logic         tmr_zero,
    output phase_e       phase,
    output logic         accept,
    output logic         sample,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val
);
    phase_e nxt;

    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sample   = 1'b0;
        accept   = 1'b0;
        case (phase)
            PH_IDLE: if (req_valid) begin
                accept = 1'b1; nxt = PH_VPP_SETUP; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            PH_VPP_SETUP: if (tmr_zero) begin
                nxt = PH_CE_SETUP; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            PH_CE_SETUP: if (tmr_zero) begin
                nxt = PH_PULSE; tmr_load = 1'b1; tmr_val = PULSE_LD;
            end
            PH_PULSE: if (tmr_zero) begin
                nxt = PH_HOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
            end
            PH_HOLD: if (tmr_zero) begin
                if (verify_q) begin
                    nxt = PH_VERIFY; tmr_load = 1'b1; tmr_val = ACCESS_LD;
                end else begin
                    nxt = PH_FINISH;
                end
            end
            PH_VERIFY: if (tmr_zero) begin
                nxt = PH_FINISH; sample = 1'b1;
            end
            PH_FINISH: nxt = PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    p_finish_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FINISH) |=> (phase == PH_IDLE));
    p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !accept);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter longint CLK_KHZ   = 50_000,
    parameter longint SETUP_NS  = 2_000,
    parameter longint PULSE_NS  = 50_000_000,
    parameter longint HOLD_NS   = 2_000,
    parameter longint ACCESS_NS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_verify,
    output logic              busy,
    output logic              done,
    output logic              mismatch,
    output logic [ADDR_W-1:0] ep_addr,
    output logic [DATA_W-1:0] ep_data_out,
    output logic              ep_data_oe,
    input  logic [DATA_W-1:0] ep_data_in,
    output logic              ep_ce_n,
    output logic              ep_oe_n,
    output logic              ep_pgm_n,
    output logic              ep_vpp_en
);
    localparam longint SETUP_CYC  = ns_to_cycles(SETUP_NS, CLK_KHZ);
    localparam longint PULSE_CYC  = ns_to_cycles(PULSE_NS, CLK_KHZ);
    localparam longint HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_KHZ);
    localparam longint ACCESS_CYC = ns_to_cycles(ACCESS_NS, CLK_KHZ);
    localparam longint MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam longint MAX_B   = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
    localparam longint MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int RUN_W = CNT_W + 1;

    phase_e          phase;
    wr_req_t         req_q;
    pin_ctl_t        pins;
    logic            accept, sample, tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= '{addr: req_addr, data: req_data, verify: req_verify};
    end

    eprom_seq_fsm #(
        .W         (CNT_W),
        .SETUP_LD  (CNT_W'(SETUP_CYC - 1)),
        .PULSE_LD  (CNT_W'(PULSE_CYC - 1)),
        .HOLD_LD   (CNT_W'(HOLD_CYC - 1)),
        .ACCESS_LD (CNT_W'(ACCESS_CYC - 1))
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .verify_q (req_q.verify),
        .tmr_zero (tmr_zero),
        .phase    (phase),
        .accept   (accept),
        .sample   (sample),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    eprom_phase_timer #(.W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    eprom_verify_cmp cmp_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .sample  (sample),
        .expected(req_q.data),
        .returned(ep_data_in),
        .mismatch(mismatch)
    );

    assign pins        = decode_pins(phase);
    assign ep_vpp_en   = pins.vpp_en;
    assign ep_ce_n     = pins.ce_n;
    assign ep_oe_n     = pins.oe_n;
    assign ep_pgm_n    = pins.pgm_n;
    assign ep_data_oe  = pins.data_oe;
    assign ep_addr     = req_q.addr;
    assign ep_data_out = req_q.data;
    assign busy        = (phase != PH_IDLE);
    assign done        = (phase == PH_FINISH);

    // Run-length counters used only by the timing properties below.
    logic [RUN_W-1:0] vpp_run, ce_run, pgm_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            vpp_run <= '0; ce_run <= '0; pgm_run <= '0;
        end else begin
            vpp_run <= ep_vpp_en ? vpp_run + 1'b1 : '0;
            ce_run  <= !ep_ce_n  ? ce_run + 1'b1  : '0;
            pgm_run <= !ep_pgm_n ? pgm_run + 1'b1 : '0;
        end
    end

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ep_addr) && $stable(ep_data_out)));
    p_vpp_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_ce_n) |-> (vpp_run == RUN_W'(SETUP_CYC)));
    p_ce_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_pgm_n) |-> (ce_run == RUN_W'(SETUP_CYC)));
    p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_pgm_n) |-> (pgm_run == RUN_W'(PULSE_CYC)));
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_pgm_n) |-> (ep_data_oe && $stable(ep_data_out)));
    p_done_pins_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (ep_ce_n && !ep_vpp_en && !ep_data_oe));
    p_no_contention_r11: assert property (@(posedge clk) disable iff (rst)
        !ep_oe_n |-> !ep_data_oe);
    p_pgm_needs_vpp_r11: assert property (@(posedge clk) disable iff (rst)
        !ep_pgm_n |-> (ep_vpp_en && !ep_ce_n && ep_data_oe));
endmodule

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
    // 250 MHz clock; timing chosen so every conversion is checked by hand:
    // setup 20 ns -> 5, pulse 200 ns -> 50, hold 14 ns -> 3.5 -> 4,
    // access 10 ns -> 2.5 -> 3 cycles.
    localparam int S = 5, P = 50, H = 4, A = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [13:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_verify = 1'b0;
    logic [7:0]  ep_data_in = '0;
    logic        busy, done, mismatch, ep_data_oe, ep_ce_n, ep_oe_n, ep_pgm_n, ep_vpp_en;
    logic [13:0] ep_addr;
    logic [7:0]  ep_data_out;

    always #2 clk = ~clk;

    eprom_prog_seq #(
        .CLK_KHZ(250_000), .SETUP_NS(20), .PULSE_NS(200), .HOLD_NS(14), .ACCESS_NS(10)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_verify(req_verify), .busy(busy), .done(done),
        .mismatch(mismatch), .ep_addr(ep_addr), .ep_data_out(ep_data_out),
        .ep_data_oe(ep_data_oe), .ep_data_in(ep_data_in), .ep_ce_n(ep_ce_n),
        .ep_oe_n(ep_oe_n), .ep_pgm_n(ep_pgm_n), .ep_vpp_en(ep_vpp_en)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: time since acceptance against phase boundaries.
    bit          m_busy = 0;
    int          t = 0;
    logic [13:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    bit          m_ver = 0;
    bit          m_mis = 0;

    function automatic int end_time(bit v);
        return 2*S + P + H + (v ? A : 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; t = 0; m_mis = 0;
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy = 1; t = 0; m_addr = req_addr; m_data = req_data;
                m_ver = req_verify; m_mis = 0;
            end
        end else begin
            if (m_ver && t == end_time(1) - 1) m_mis = (ep_data_in != m_data);
            if (t == end_time(m_ver)) m_busy = 0;
            else t++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int e;
            bit vw, dwin;
            e    = end_time(m_ver);
            vw   = m_busy && m_ver && t >= 2*S + P + H && t < e;
            dwin = m_busy && t < 2*S + P + H;
            chk("R2/R9 busy", busy, m_busy);
            chk("R8 done", done, m_busy && t == e);
            chk("R3 vpp_en", ep_vpp_en, m_busy && t < e);
            chk("R4 ce_n", ep_ce_n, !(m_busy && t >= S && t < e));
            chk("R5 pgm_n", ep_pgm_n, !(m_busy && t >= 2*S && t < 2*S + P));
            chk("R6 data_oe", ep_data_oe, dwin);
            chk("R7 oe_n", ep_oe_n, !vw);
            chk("R7/R10 mismatch", mismatch, m_mis);
            if (m_busy) begin
                chk("R2/R9 addr", ep_addr, m_addr);
                chk("R2/R9 data", ep_data_out, m_data);
            end
            if (!ep_oe_n && ep_data_oe) chk("R11 contention", 1, 0);
        end
    end

    task automatic one_write(input logic [13:0] a, input logic [7:0] d, input bit v,
                             input logic [7:0] resp);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d; req_verify = v; ep_data_in = resp;
        @(negedge clk);
        req_valid = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);           chk("R1 done", done, 0);
        chk("R1 mismatch", mismatch, 0);   chk("R1 vpp_en", ep_vpp_en, 0);
        chk("R1 data_oe", ep_data_oe, 0);  chk("R1 ce_n", ep_ce_n, 1);
        chk("R1 oe_n", ep_oe_n, 1);        chk("R1 pgm_n", ep_pgm_n, 1);

        one_write(14'h0000, 8'h00, 0, 8'hFF);     // plain write, lowest address
        one_write(14'h3FFF, 8'hA5, 1, 8'hA5);     // R7 verify, match, top address
        one_write(14'h1234, 8'h3C, 1, 8'h3D);     // R7 verify, mismatch
        chk("R7 mismatch held", mismatch, 1);
        one_write(14'h0ABC, 8'h77, 0, 8'h00);     // R10 cleared, non-verify run
        chk("R10 mismatch cleared", mismatch, 0);

        // R9: req_valid held high with a new address each cycle; one lands on done.
        ep_data_in = 8'h11;
        for (int i = 0; i < 3 * end_time(1); i++) begin
            @(negedge clk);
            req_valid = 1; req_addr = 14'(i * 37); req_data = 8'(i);
            req_verify = i[0];
        end
        @(negedge clk);
        req_valid = 0;
        while (m_busy) @(negedge clk);

        // Reset in the middle of the strobe returns to the R1 state.
        one_write(14'h2000, 8'h5A, 1, 8'h5A);
        @(negedge clk);
        req_valid = 1; req_addr = 14'h0101; req_data = 8'hC3; req_verify = 1;
        @(negedge clk);
        req_valid = 0;
        repeat (2*S + 10) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 pgm_n after reset", ep_pgm_n, 1);
        chk("R1 vpp_en after reset", ep_vpp_en, 0);
        one_write(14'h0101, 8'hC3, 1, 8'h43);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50_000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule